// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits between a host's byte-write cycles and the page buffer of a nonvolatile byte-wide memory. It examines each accepted write, made up of an address and a data byte, and recognises multi-write unlock commands. All commands share a two-write key. A third write either finishes a short command or leads into a six-write extended command.

The recognised commands are:
- switch on the global write protection and open a protected page load;
- switch the protection off;
- start a full-array erase;
- enter or leave the identification mode.

While the identification mode is active, reads at the two lowest identification addresses return fixed manufacturer and device codes instead of array data.

Bytes that are not part of a command go to the external page buffer as ordinary byte loads. This happens only when protection is off, or when a protected load has been opened by the short command. While protection is on, an unkeyed write is dropped, and the decoder then refuses all writes for a fixed lockout window. The page buffer, the write and erase timers and the array are outside the block. The block sees the write or erase engine only through a busy input, and writes arriving while it is high are ignored.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, protection, identification mode, page permit, erase start, lockout and load valid are all 0.
- R2: With protection off, an accepted write that is not a step of a command appears on the load outputs one cycle later, with its address and data unchanged. A write that is consumed as a command step never raises load_valid.
- R3: The key is data 0xAA at address 0x5555 followed by data 0x55 at address 0x2AAA. Only address bits [14:0] take part in every command address compare, and bit 15 is ignored.
- R4: The key followed by 0xA0 at 0x5555 sets protection and the page permit. While the permit is set, non-command writes are loaded even though protection is on. The permit clears when busy_i is high.
- R5: The key, 0x80 at 0x5555, the key again, and then a final byte at 0x5555 form the extended command. With a final byte of 0x20, protection and the permit are cleared. With a final byte of 0x10, erase_start is high for exactly one cycle.
- R6: The key followed by 0x90, or the extended command with a final byte of 0x60, sets identification mode. The key followed by 0xF0 clears it.
- R7: In identification mode, a read whose address bits [14:1] are zero returns 0xBF when bit 0 is 0 and 0x5D when bit 0 is 1. Every other read, and every read outside this mode, returns arr_rd_data.
- R8: With protection on and no permit, a non-command write is not loaded. lockout then stays high for LOCK_CYC cycles, and writes during that window have no effect.
- R9: Writes presented while busy_i is high are ignored. They produce no load and no change of mode.
- R10: A write that does not match the expected next step ends the sequence in progress. It is handled as a non-command byte, and a new sequence must start again from the first key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One byte-write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy_i | input | 1 | External write or erase engine busy |
| rd_addr | input | ADDR_W | Read address |
| arr_rd_data | input | 8 | Data read from the array at rd_addr |
| rd_data | output | 8 | Read data returned to the host |
| load_valid | output | 1 | Byte-load strobe to the page buffer |
| load_addr | output | ADDR_W | Byte-load address |
| load_data | output | 8 | Byte-load data |
| prot_on | output | 1 | Global write protection active |
| page_permit | output | 1 | Protected page load open |
| id_mode | output | 1 | Identification mode active |
| erase_start | output | 1 | One-cycle full-array erase request |
| lockout | output | 1 | Writes refused after a dropped write |

## Verification
The hardest states to reach are at the end of the six-write extended command. They need the key twice, with the extension byte between the two keys, and no stray write anywhere in the chain. The bench also sweeps all 256 values of the third byte after the key. Each value is followed by the exact sequence that returns the decoder to a clean state, which exercises every short command and every mismatch path. The lockout window is entered deliberately by dropping an unkeyed write under protection, and its length is then counted.

// File: rtl/ucd_pkg.sv
// Shared constants and types for the unlock-sequence command decoder.
// Assumes command addresses are compared on the low KEY_W address bits only.
package ucd_pkg;
    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_DATA_A    = 8'hAA;
    localparam logic [7:0] KEY_DATA_B    = 8'h55;
    localparam logic [7:0] OP_PROT_WRITE = 8'hA0;
    localparam logic [7:0] OP_EXTEND     = 8'h80;
    localparam logic [7:0] OP_ID_ENTER   = 8'h90;
    localparam logic [7:0] OP_ID_LEAVE   = 8'hF0;
    localparam logic [7:0] OP_UNPROTECT  = 8'h20;
    localparam logic [7:0] OP_ERASE      = 8'h10;
    localparam logic [7:0] OP_ID_ALT     = 8'h60;

    localparam logic [7:0] MFR_CODE = 8'hBF;
    localparam logic [7:0] DEV_CODE = 8'h5D;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT3,
        ST_EXT4,
        ST_EXT5
    } seq_state_e;

    typedef struct packed {
        logic consumed;
        logic prot_set;
        logic prot_clr;
        logic erase;
        logic id_set;
        logic id_clr;
    } seq_event_t;
endpackage

// File: rtl/ucd_seq_fsm.sv
// Sequence recogniser: tracks the unlock key and the extended command.
// Emits one event vector per accepted write. Assumes 'take' is already
// qualified by busy and lockout, and receives only the compared address bits.
module ucd_seq_fsm
    import ucd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       data,
    output seq_event_t       ev,
    output logic             stray
);
    seq_state_e state_q, state_d;
    logic at_a, hit_a, hit_b;

    assign at_a  = (key_addr == KEY_ADDR_A);
    assign hit_a = at_a && (data == KEY_DATA_A);
    assign hit_b = (key_addr == KEY_ADDR_B) && (data == KEY_DATA_B);

    // Decode the step expected in the current state.
    always_comb begin
        ev      = '0;
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: if (hit_a) begin ev.consumed = 1'b1; state_d = ST_KEY1; end
            ST_KEY1: if (hit_b) begin ev.consumed = 1'b1; state_d = ST_KEY2; end
            ST_KEY2: if (at_a) begin
                unique case (data)
                    OP_PROT_WRITE: begin ev.consumed = 1'b1; ev.prot_set = 1'b1; end
                    OP_ID_ENTER:   begin ev.consumed = 1'b1; ev.id_set   = 1'b1; end
                    OP_ID_LEAVE:   begin ev.consumed = 1'b1; ev.id_clr   = 1'b1; end
                    OP_EXTEND:     begin ev.consumed = 1'b1; state_d = ST_EXT3; end
                    default: ;
                endcase
            end
            ST_EXT3: if (hit_a) begin ev.consumed = 1'b1; state_d = ST_EXT4; end
            ST_EXT4: if (hit_b) begin ev.consumed = 1'b1; state_d = ST_EXT5; end
            ST_EXT5: if (at_a) begin
                unique case (data)
                    OP_UNPROTECT: begin ev.consumed = 1'b1; ev.prot_clr = 1'b1; end
                    OP_ERASE:     begin ev.consumed = 1'b1; ev.erase    = 1'b1; end
                    OP_ID_ALT:    begin ev.consumed = 1'b1; ev.id_set   = 1'b1; end
                    default: ;
                endcase
            end
            default: ;
        endcase
        if (!take) ev = '0;
    end

    assign stray = take && !ev.consumed;

    // Advance on accepted writes; a mismatch returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= ST_IDLE;
        else if (take) state_q <= state_d;
    end
endmodule

// File: rtl/ucd_mode_ctrl.sv
// Mode registers, lockout timer and byte-load forwarding.
// Assumes events arrive only for accepted writes. Loads are registered,
// so they appear one cycle after the write.
module ucd_mode_ctrl
    import ucd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LOCK_CYC = 75000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_event_t        ev,
    input  logic              stray,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              prot_on,
    output logic              page_permit,
    output logic              id_mode,
    output logic              erase_start,
    output logic              lockout,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    logic [CNT_W-1:0] lock_cnt;
    logic             may_load;

    assign may_load = !prot_on || page_permit;
    assign lockout  = (lock_cnt != '0);

    // Global protection and protected-load permit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on     <= 1'b0;
            page_permit <= 1'b0;
        end else begin
            if (ev.prot_set) prot_on <= 1'b1;
            else if (ev.prot_clr) prot_on <= 1'b0;
            if (ev.prot_set) page_permit <= 1'b1;
            else if (ev.prot_clr || busy_i) page_permit <= 1'b0;
        end
    end

    // Identification mode; not kept across reset.
    always_ff @(posedge clk) begin
        if (!rst_n) id_mode <= 1'b0;
        else if (ev.id_set) id_mode <= 1'b1;
        else if (ev.id_clr) id_mode <= 1'b0;
    end

    // One-cycle erase request.
    always_ff @(posedge clk) begin
        if (!rst_n) erase_start <= 1'b0;
        else        erase_start <= ev.erase;
    end

    // Lockout window after a dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_cnt <= '0;
        else if (stray && !may_load) lock_cnt <= CNT_W'(LOCK_CYC);
        else if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
    end

    // Forward non-command bytes to the page buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid <= 1'b0;
            load_addr  <= '0;
            load_data  <= '0;
        end else begin
            load_valid <= stray && may_load;
            if (stray && may_load) begin
                load_addr <= wr_addr;
                load_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ucd_id_read.sv
// Read-path multiplexer: substitutes the identification codes in ID mode.
// Assumes only address bits [KEY_W-1:0] are decoded.
module ucd_id_read
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rd_data,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] DEC_MASK = ADDR_W'((64'd1 << KEY_W) - 64'd1);

    logic [ADDR_W-1:0] dec_addr;
    logic              id_hit;

    assign dec_addr = rd_addr & DEC_MASK;
    assign id_hit   = id_mode && (dec_addr[ADDR_W-1:1] == '0);

    // Choose between an identification code and array data.
    always_comb begin
        if (id_hit) rd_data = dec_addr[0] ? DEV_CODE : MFR_CODE;
        else        rd_data = arr_rd_data;
    end
endmodule

// File: rtl/unlock_cmd_decoder.sv
// Top level of the unlock-sequence command decoder. Qualifies each write with
// busy and lockout, then feeds the recogniser, mode control and read mux.
// Assumes ADDR_W >= 16 and one write per wr_valid cycle.
module unlock_cmd_decoder
    import ucd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LOCK_CYC = 75000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rd_data,
    output logic [7:0]        rd_data,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              prot_on,
    output logic              page_permit,
    output logic              id_mode,
    output logic              erase_start,
    output logic              lockout
);
    seq_event_t ev;
    logic       stray;
    logic       take;

    // A write is accepted only when the engine is idle and no lockout runs.
    assign take = wr_valid && !busy_i && !lockout;

    ucd_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .key_addr (wr_addr[KEY_W-1:0]),
        .data     (wr_data),
        .ev       (ev),
        .stray    (stray)
    );

    ucd_mode_ctrl #(.ADDR_W(ADDR_W), .LOCK_CYC(LOCK_CYC)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .stray       (stray),
        .busy_i      (busy_i),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .prot_on     (prot_on),
        .page_permit (page_permit),
        .id_mode     (id_mode),
        .erase_start (erase_start),
        .lockout     (lockout),
        .load_valid  (load_valid),
        .load_addr   (load_addr),
        .load_data   (load_data)
    );

    ucd_id_read #(.ADDR_W(ADDR_W)) u_rd (
        .id_mode     (id_mode),
        .rd_addr     (rd_addr),
        .arr_rd_data (arr_rd_data),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/unlock_cmd_decoder_chk.sv
// Checker for the unlock-sequence command decoder, bound to every instance.
module unlock_cmd_decoder_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              busy_i,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        arr_rd_data,
    input logic [7:0]        rd_data,
    input logic              load_valid,
    input logic [ADDR_W-1:0] load_addr,
    input logic [7:0]        load_data,
    input logic              prot_on,
    input logic              page_permit,
    input logic              id_mode,
    input logic              erase_start,
    input logic              lockout
);
    // R5
    erase_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R8
    no_load_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(!prot_on || page_permit));

    // R8
    lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !load_valid);

    // R9
    busy_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(wr_valid && !busy_i));

    // R4
    prot_rise_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_valid) && $past(wr_addr[14:0] == 15'h5555));

    // R7
    plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> rd_data == arr_rd_data);

    // R7
    mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_addr[14:0] == 15'h0000) |-> rd_data == 8'hBF);

    // R4
    permit_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_permit |-> prot_on);
endmodule

bind unlock_cmd_decoder unlock_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/unlock_cmd_decoder_tb.sv
// Self-checking bench for the unlock-sequence command decoder.
module unlock_cmd_decoder_tb;
    localparam int AW     = 16;
    localparam int LOCK_T = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy_i = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_rd_data;
    logic [7:0]    rd_data;
    logic          load_valid;
    logic [AW-1:0] load_addr;
    logic [7:0]    load_data;
    logic          prot_on, page_permit, id_mode, erase_start, lockout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign arr_rd_data = rd_addr[7:0] ^ 8'h3C;

    unlock_cmd_decoder #(.ADDR_W(AW), .LOCK_CYC(LOCK_T)) u_dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; presents one write across the next posedge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic key();
        wr(16'h5555, 8'hAA);
        check(!load_valid, "R2 key byte1 not loaded", load_valid, 0);
        wr(16'h2AAA, 8'h55);
        check(!load_valid, "R2 key byte2 not loaded", load_valid, 0);
    endtask

    task automatic ext(input logic [7:0] fin);
        key(); wr(16'h5555, 8'h80); key(); wr(16'h5555, fin);
    endtask

    task automatic expect_load(input string req, input logic [AW-1:0] a, input logic [7:0] d);
        check(load_valid === 1'b1, req, load_valid, 1);
        check(load_addr == a && load_data == d, req, {load_addr, load_data}, {a, d});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({prot_on, id_mode, page_permit, erase_start, lockout, load_valid} == 6'b0,
              "R1 reset outputs", {prot_on, id_mode, page_permit, erase_start, lockout, load_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 plain byte forwarded
        wr(16'h1234, 8'h5A);
        expect_load("R2 plain forward", 16'h1234, 8'h5A);
        @(negedge clk);
        check(!load_valid, "R2 single strobe", load_valid, 0);

        // R2/R4/R6/R10 sweep of the third byte after the key
        for (int d = 0; d < 256; d++) begin
            key();
            wr(16'h5555, 8'(d));
            if (d == 8'hA0) begin
                check(prot_on && page_permit && !load_valid, "R4 prot write cmd", {prot_on, page_permit}, 3);
                ext(8'h20);
                check(!prot_on && !page_permit, "R5 unprotect", {prot_on, page_permit}, 0);
            end else if (d == 8'h90) begin
                check(id_mode && !load_valid, "R6 id enter", id_mode, 1);
                key(); wr(16'h5555, 8'hF0);
                check(!id_mode && !load_valid, "R6 id leave", id_mode, 0);
            end else if (d == 8'hF0) begin
                check(!id_mode && !load_valid, "R6 leave while out", id_mode, 0);
            end else if (d == 8'h80) begin
                check(!load_valid, "R2 extend byte not loaded", load_valid, 0);
                wr(16'h0042, 8'h00);
                expect_load("R10 mismatch after extend", 16'h0042, 8'h00);
            end else begin
                expect_load("R10 stray third byte", 16'h5555, 8'(d));
                check(!prot_on && !id_mode, "R10 no mode change", {prot_on, id_mode}, 0);
            end
        end

        // R10 mismatch at second step restarts only from the first key write
        wr(16'h5555, 8'hAA);
        wr(16'h2AAB, 8'h55);
        expect_load("R10 bad second key", 16'h2AAB, 8'h55);
        wr(16'h5555, 8'h90);
        expect_load("R10 no resume", 16'h5555, 8'h90);
        check(!id_mode, "R10 no id after break", id_mode, 0);

        // R3 address bit 15 ignored; R6 alternate id entry
        wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'hD555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'hD555, 8'h60);
        check(id_mode, "R3 R6 alt id entry with bit15 set", id_mode, 1);

        // R7 identification reads
        rd_addr = 16'h0000; #1;
        check(rd_data == 8'hBF, "R7 mfr code", rd_data, 8'hBF);
        rd_addr = 16'h0001; #1;
        check(rd_data == 8'h5D, "R7 dev code", rd_data, 8'h5D);
        rd_addr = 16'h8001; #1;
        check(rd_data == 8'h5D, "R7 bit15 ignored", rd_data, 8'h5D);
        for (int a = 2; a < 40; a += 3) begin
            rd_addr = 16'(a); #1;
            check(rd_data == (8'(a) ^ 8'h3C), "R7 array in id mode", rd_data, 8'(a) ^ 8'h3C);
        end
        @(negedge clk);
        key(); wr(16'h5555, 8'hF0);
        rd_addr = 16'h0001; #1;
        check(rd_data == (8'h01 ^ 8'h3C), "R7 array after leave", rd_data, 8'h01 ^ 8'h3C);
        @(negedge clk);

        // R5 erase pulse
        ext(8'h10);
        check(erase_start && !load_valid, "R5 erase start", erase_start, 1);
        @(negedge clk);
        check(!erase_start, "R5 erase one cycle", erase_start, 0);

        // R9 busy ignores writes
        busy_i = 1'b1;
        wr(16'h0077, 8'h11);
        check(!load_valid, "R9 busy no load", load_valid, 0);
        key(); wr(16'h5555, 8'h90);
        check(!id_mode, "R9 busy no command", id_mode, 0);
        busy_i = 1'b0;

        // R4 protected page load then permit closed by busy
        key(); wr(16'h5555, 8'hA0);
        for (int i = 0; i < 4; i++) begin
            wr(16'h0300 + 16'(i), 8'(8'hC0 + i));
            expect_load("R4 permitted load", 16'h0300 + 16'(i), 8'(8'hC0 + i));
        end
        busy_i = 1'b1; @(negedge clk); busy_i = 1'b0;
        check(prot_on && !page_permit, "R4 permit cleared by busy", {prot_on, page_permit}, 2);

        // R8 unkeyed write dropped, lockout window
        wr(16'h0400, 8'h99);
        check(!load_valid && lockout, "R8 drop and lock", {load_valid, lockout}, 1);
        wr(16'h0401, 8'h98);
        check(!load_valid, "R8 ignored in lockout", load_valid, 0);
        begin
            int n = 0;
            while (lockout && n < 100) begin n++; @(negedge clk); end
            check(n == LOCK_T - 1, "R8 lockout length", n, LOCK_T - 1);
        end
        check(prot_on, "R8 protection kept", prot_on, 1);

        // R4 keyed write works again under protection
        key(); wr(16'h5555, 8'hA0);
        wr(16'h0500, 8'h42);
        expect_load("R4 keyed protected load", 16'h0500, 8'h42);

        // R5 unprotect then plain forward
        ext(8'h20);
        check(!prot_on, "R5 prot off", prot_on, 0);
        wr(16'h0600, 8'h24);
        expect_load("R2 forward after unprotect", 16'h0600, 8'h24);

        // R1 reset clears id mode
        key(); wr(16'h5555, 8'h90);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check(!id_mode, "R1 id cleared by reset", id_mode, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule